// File: doc/BRIEF.md
# Serial Tuning-Word and Control Receiver

This block takes configuration from a host controller over a three-wire synchronous serial link: a serial clock, a data line and a load-enable that frames each word. Every word is 16 bits. The first bit shifted in is a routing bit, and the fifteen bits after it are the payload. When a frame closes, a format check decides whether the payload is written into the frequency register (register A) or the control register (register B), or whether the whole word is thrown away.

Register A holds the divider ratio as an unsigned binary number, and the block keeps it inside the legal divider range. Register B holds control settings, and three of its fields are decoded onto ports of their own: band, reference rate and charge-pump gain. All three serial lines are brought into the system clock domain through synchronizers, and all decisions are made there. When a word is accepted, the block raises a one-cycle update strobe and shows which register was written. When a word is discarded, it raises a one-cycle reject strobe and sets a sticky error flag.

Top module: `tuneSerialRx`

## Requirements
- R1: After reset, wordA is 512, wordB is 0 (AM band, 32 kHz reference, pump gain 0), both strobes are low and frameErr is low.
- R2: A data bit is taken only on a rising serial clock while serLoad is high, and bits arrive most significant first. Serial clock edges while serLoad is low have no effect on any output.
- R3: A 16-bit frame whose first bit is 0 and whose 15-bit payload is at least 512 writes the payload into wordA and leaves wordB unchanged. It gives one updStrobe cycle with updTarget = 0.
- R4: A 16-bit frame whose first bit is 1 writes the payload into wordB and leaves wordA unchanged. It gives one updStrobe cycle with updTarget = 1.
- R5: A frame with any number of serial clocks other than 16 (including none) changes neither register. It gives one rejStrobe cycle and sets frameErr.
- R6: A frame routed to register A whose payload is below 512 is discarded in the same way as in R5.
- R7: frameErr stays set until the next accepted word and clears in the cycle that word's updStrobe appears.
- R8: updStrobe and rejStrobe are each one cycle wide, they are never high together, and each closing frame produces exactly one of them.
- R9: bandFm is wordB bit 0 (1 = FM), refHigh is wordB bit 1 (1 = 40 kHz reference), and pumpGain is wordB bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial bit clock from the host |
| serData | input | 1 | Serial data, most significant bit first |
| serLoad | input | 1 | Frame enable, high for the whole transfer |
| wordA | output | 15 | Frequency (divider) register |
| wordB | output | 15 | Control register |
| updStrobe | output | 1 | One-cycle pulse when a word is accepted |
| updTarget | output | 1 | Register written by the last accepted word (1 = B) |
| rejStrobe | output | 1 | One-cycle pulse when a word is discarded |
| frameErr | output | 1 | Sticky flag for a discarded word |
| bandFm | output | 1 | Band select decoded from wordB |
| refHigh | output | 1 | Reference rate select decoded from wordB |
| pumpGain | output | 2 | Charge-pump gain decoded from wordB |

## Verification
The cases that are hardest to reach from the ports are frames with the wrong length: one serial clock short, one too many, and a frame with no clocks at all. The driver task takes the bit count as an argument, so it can close a frame after 15 or 17 clocks or after none. It also toggles the serial clock while the frame enable is low before it sends a real word. The scoreboard computes the expected outcome of every frame, accept or reject, and checks that a stray edge produces no strobe of any kind. It also checks that the error flag is held through later rejects and cleared by the first word that is accepted.

// File: rtl/tuneSerialRx_pkg.sv
package tuneSerialRx_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic writeA;
    logic writeB;
    logic reject;
  } rxCmd_t;

endpackage

// File: rtl/tuneSyncChain.sv
module tuneSyncChain #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  // One register per stage; the loop builds the chain
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[s] <= '0;
      end else if (s == 0) begin
        stage[s] <= asyncIn;
      end else begin
        stage[s] <= stage[(s > 0) ? s-1 : 0];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/tuneRxCtrl.sv
module tuneRxCtrl
  import tuneSerialRx_pkg::*;
#(
  parameter int SH_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   serClk,
  input  logic   serData,
  input  logic   serLoad,
  input  logic   routeB,
  input  logic   aTooLow,
  output rxCmd_t cmd
);

  localparam int CNT_W   = $clog2(SH_W + 2);
  localparam int CNT_MAX = SH_W + 1;

  logic [2:0]       syncd;
  logic             sClk, sData, sLoad;
  logic             clkDly, loadDly;
  logic             clkRise, loadRise, loadFall;
  logic [CNT_W-1:0] bitCnt;
  logic             fullWord;

  tuneSyncChain #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({serClk, serData, serLoad}),
    .syncOut(syncd)
  );

  assign sClk  = syncd[2];
  assign sData = syncd[1];
  assign sLoad = syncd[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkDly  <= 1'b0;
      loadDly <= 1'b0;
    end else begin
      clkDly  <= sClk;
      loadDly <= sLoad;
    end
  end

  assign clkRise  = sClk & ~clkDly;
  assign loadRise = sLoad & ~loadDly;
  assign loadFall = ~sLoad & loadDly;

  // The count saturates one above a full word, so any overrun is still seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (loadRise) begin
      bitCnt <= '0;
    end else if (clkRise && sLoad && bitCnt != CNT_W'(CNT_MAX)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign fullWord = (bitCnt == CNT_W'(SH_W));

  always_comb begin
    cmd          = '0;
    cmd.shiftEn  = clkRise & sLoad;
    cmd.shiftBit = sData;
    cmd.writeB   = loadFall & fullWord & routeB;
    cmd.writeA   = loadFall & fullWord & ~routeB & ~aTooLow;
    cmd.reject   = loadFall & ~(fullWord & (routeB | ~aTooLow));
  end

  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.writeA, cmd.writeB, cmd.reject}));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CNT_MAX));

  p_close_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writeA | cmd.writeB | cmd.reject) |=> !(cmd.writeA | cmd.writeB | cmd.reject));

endmodule

// File: rtl/tuneRxData.sv
module tuneRxData
  import tuneSerialRx_pkg::*;
#(
  parameter int PAY_W   = 15,
  parameter int MIN_DIV = 512,
  parameter int B_RESET = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxCmd_t           cmd,
  output logic             routeB,
  output logic             aTooLow,
  output logic [PAY_W-1:0] wordA,
  output logic [PAY_W-1:0] wordB,
  output logic             updStrobe,
  output logic             updTarget,
  output logic             rejStrobe,
  output logic             frameErr
);

  localparam int SH_W = PAY_W + 1;

  logic [SH_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (cmd.shiftEn) begin
      shReg <= {shReg[SH_W-2:0], cmd.shiftBit};
    end
  end

  assign routeB  = shReg[SH_W-1];
  assign aTooLow = shReg[PAY_W-1:0] < PAY_W'(MIN_DIV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordA     <= PAY_W'(MIN_DIV);
      wordB     <= PAY_W'(B_RESET);
      updStrobe <= 1'b0;
      updTarget <= 1'b0;
      rejStrobe <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      updStrobe <= cmd.writeA | cmd.writeB;
      rejStrobe <= cmd.reject;
      if (cmd.writeA) begin
        wordA     <= shReg[PAY_W-1:0];
        updTarget <= 1'b0;
        frameErr  <= 1'b0;
      end
      if (cmd.writeB) begin
        wordB     <= shReg[PAY_W-1:0];
        updTarget <= 1'b1;
        frameErr  <= 1'b0;
      end
      if (cmd.reject) begin
        frameErr <= 1'b1;
      end
    end
  end

  p_a_floor_r6: assert property (@(posedge clk) disable iff (!rstN)
    wordA >= PAY_W'(MIN_DIV));

  p_strobe_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |=> !updStrobe);

  p_no_both_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(updStrobe && rejStrobe));

  p_b_keeps_a_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe && updTarget) |-> $stable(wordA));

  p_a_keeps_b_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe && !updTarget) |-> $stable(wordB));

  p_rej_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    rejStrobe |-> ($stable(wordA) && $stable(wordB) && frameErr));

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> !frameErr);

endmodule

// File: rtl/tuneSerialRx.sv
module tuneSerialRx
  import tuneSerialRx_pkg::*;
#(
  parameter int PAY_W       = 15,
  parameter int MIN_DIV     = 512,
  parameter int B_RESET     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLoad,
  output logic [PAY_W-1:0] wordA,
  output logic [PAY_W-1:0] wordB,
  output logic             updStrobe,
  output logic             updTarget,
  output logic             rejStrobe,
  output logic             frameErr,
  output logic             bandFm,
  output logic             refHigh,
  output logic [1:0]       pumpGain
);

  localparam int SH_W = PAY_W + 1;

  rxCmd_t cmd;
  logic   routeB;
  logic   aTooLow;

  tuneRxCtrl #(.SH_W(SH_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .serLoad(serLoad),
    .routeB (routeB),
    .aTooLow(aTooLow),
    .cmd    (cmd)
  );

  tuneRxData #(.PAY_W(PAY_W), .MIN_DIV(MIN_DIV), .B_RESET(B_RESET)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .routeB   (routeB),
    .aTooLow  (aTooLow),
    .wordA    (wordA),
    .wordB    (wordB),
    .updStrobe(updStrobe),
    .updTarget(updTarget),
    .rejStrobe(rejStrobe),
    .frameErr (frameErr)
  );

  // Control field decode (R9)
  assign bandFm   = wordB[0];
  assign refHigh  = wordB[1];
  assign pumpGain = wordB[3:2];

endmodule

// File: tb/test_tuneSerialRx.sv
`timescale 1ns/1ps
module test_tuneSerialRx;

  typedef struct packed {
    logic        acc;
    logic        tgt;
    logic [14:0] a;
    logic [14:0] b;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        serLoad = 1'b0;
  logic [14:0] wordA, wordB;
  logic        updStrobe, updTarget, rejStrobe, frameErr;
  logic        bandFm, refHigh;
  logic [1:0]  pumpGain;

  int   nChecks = 0;
  int   nFails  = 0;
  exp_t expQ[$];
  logic [14:0] modelA = 15'd512;
  logic [14:0] modelB = 15'd0;
  logic        modelErr = 1'b0;
  bit          done = 0;

  always #2 clk = ~clk;

  tuneSerialRx i_tuneSerialRx (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .wordA(wordA), .wordB(wordB), .updStrobe(updStrobe), .updTarget(updTarget),
    .rejStrobe(rejStrobe), .frameErr(frameErr), .bandFm(bandFm), .refHigh(refHigh),
    .pumpGain(pumpGain)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic waitSys(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: sends nBits from the low end of v, most significant first,
  // and pushes the expected outcome
  task automatic sendFrame(input logic [31:0] v, input int nBits);
    exp_t e;
    logic [14:0] pay;
    serLoad = 1'b1;
    waitSys(4);
    for (int i = nBits - 1; i >= 0; i--) begin
      serData = v[i];
      waitSys(3);
      serClk = 1'b1;
      waitSys(3);
      serClk = 1'b0;
    end
    waitSys(3);
    pay = v[14:0];
    if (nBits == 16 && v[15]) begin
      modelB = pay; modelErr = 1'b0;
      e = '{acc: 1'b1, tgt: 1'b1, a: modelA, b: modelB, err: 1'b0};
    end else if (nBits == 16 && pay >= 15'd512) begin
      modelA = pay; modelErr = 1'b0;
      e = '{acc: 1'b1, tgt: 1'b0, a: modelA, b: modelB, err: 1'b0};
    end else begin
      modelErr = 1'b1;
      e = '{acc: 1'b0, tgt: 1'b0, a: modelA, b: modelB, err: 1'b1};
    end
    expQ.push_back(e);
    serLoad = 1'b0;
    for (int k = 0; k < 30 && expQ.size() != 0; k++) waitSys(1);
    chk(expQ.size() == 0, "R8 strobe for closed frame", expQ.size(), 0);
    expQ.delete();
    waitSys(4);
  endtask

  // Monitor: pops one expected item per strobe
  always @(negedge clk) begin
    if (rstN && (updStrobe || rejStrobe)) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2/R8 unexpected strobe", {updStrobe, rejStrobe}, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(!(updStrobe && rejStrobe), "R8 both strobes", 1, 0);
        chk(updStrobe == e.acc, e.acc ? "R3/R4 accept" : "R5/R6 reject", updStrobe, e.acc);
        if (e.acc) chk(updTarget == e.tgt, "R3/R4 updTarget", updTarget, e.tgt);
        chk(wordA == e.a, "R3/R5 wordA", wordA, e.a);
        chk(wordB == e.b, "R4/R5 wordB", wordB, e.b);
        chk(frameErr == e.err, "R7 frameErr", frameErr, e.err);
        chk({pumpGain, refHigh, bandFm} == e.b[3:0], "R9 fields",
            {pumpGain, refHigh, bandFm}, e.b[3:0]);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    waitSys(5);
    rstN = 1'b1;
    waitSys(3);
    // R1 reset state
    chk(wordA == 15'd512, "R1 wordA", wordA, 512);
    chk(wordB == 15'd0, "R1 wordB", wordB, 0);
    chk(!updStrobe && !rejStrobe, "R1 strobes", {updStrobe, rejStrobe}, 0);
    chk(!frameErr, "R1 frameErr", frameErr, 0);
    chk(!bandFm && !refHigh && pumpGain == 2'd0, "R1 fields", {pumpGain, refHigh, bandFm}, 0);

    sendFrame(32'h0000_03E8, 16);           // R3 A = 1000
    sendFrame(32'h0000_800B, 16);           // R4 B = 0b1011, R9
    sendFrame(32'h0000_7FFF, 16);           // R3 A at max
    sendFrame(32'h0000_0200, 16);           // R3 A at floor 512
    sendFrame(32'h0000_01FF, 16);           // R6 A below floor
    sendFrame(32'h0000_4000, 15);           // R5 short frame
    sendFrame(32'h0000_8006, 15);           // R5 short frame, error stays set
    sendFrame(32'h0001_1234, 17);           // R5 long frame
    sendFrame(32'h0000_0000, 0);            // R5 empty frame
    sendFrame(32'h0000_1234, 16);           // R7 accepted word clears error

    // R2: clocks while serLoad low must do nothing
    for (int i = 0; i < 20; i++) begin
      serData = i[0];
      waitSys(3); serClk = 1'b1; waitSys(3); serClk = 1'b0;
    end
    waitSys(10);
    chk(wordA == modelA && wordB == modelB, "R2 idle clocks", {wordA, wordB}, {modelA, modelB});
    sendFrame(32'h0000_FFF6, 16);           // R2/R4 B = 0x7FF6, MSB-first
    sendFrame(32'h0000_C005, 16);           // R4 B = 0x4005
    sendFrame(32'h0000_2A55, 16);           // R3 A = 0x2A55

    chk(wordA == 15'h2A55, "R3 final wordA", wordA, 15'h2A55);
    chk(wordB == 15'h4005, "R4 final wordB", wordB, 15'h4005);
    done = 1;
    summary();
  end

endmodule